// File: doc/BRIEF.md
# Common-Mode Switched SAR Conversion Sequencer

This block runs the digital side of a 12-bit fully differential successive-approximation converter. The converter's split capacitor array parks every capacitor on the common-mode level while sampling. A start pulse opens a short sampling window. Twelve clocked decisions then follow, one per cycle, each driven by a single comparator bit. After each decision the block moves one capacitor pair off common-mode. The positive half goes one way and the negative half goes the opposite way, so that the remaining residue is halved.

When the last decision is taken, a signed digital trim is subtracted from the raw code, and the result is clamped to the code range. The result is presented together with a single-cycle end-of-conversion strobe. With two sampling cycles, a full conversion takes fourteen clock cycles. This allows a new start to be accepted on the same edge that takes the last decision, which gives one result every fourteen cycles.

Top module: `sar_vcm_ctrl`

## Requirements
- R1: After reset, and whenever no conversion is running, every capacitor control selects common-mode on both halves, `sample_o` is low, `eoc_o` is low and `data_o` is 0.
- R2: On each half, for every capacitor position, exactly one of the reference-high, reference-low and common-mode controls is high in every cycle.
- R3: The two halves are always complementary: a capacitor at reference-low on the positive half is at reference-high on the negative half, the reverse also holds, and common-mode is shared.
- R4: A start sampled while idle gives exactly two cycles with `sample_o` high. During those cycles, and in the following cycle in which the MSB is decided, all capacitors are at common-mode.
- R5: Bits are decided MSB first, and bit k is taken from `cmp_i` (1 means the positive side is higher, giving a result bit of 1). On the edge that decides bit k, capacitor k moves to reference-low on the positive half and reference-high on the negative half when the bit is 1, and to the opposite references when it is 0. It stays there until the conversion ends.
- R6: With a comparator that follows the switched array, the raw code equals the differential input plus comparator offset plus 2048, clamped to 0..4095.
- R7: `eoc_o` is high for exactly one cycle, and it becomes visible 14 clock edges after the edge that sampled the start.
- R8: `data_o` changes only together with `eoc_o` and holds its value between strobes.
- R9: `trim_i` is a two's-complement 6-bit value, captured on the edge that accepts the start and subtracted from the raw code. Changes to `trim_i` during a conversion have no effect on that conversion.
- R10: The trimmed result saturates at 0 and 4095.
- R11: A start pulse during sampling or deciding (other than on the last decision edge) is ignored.
- R12: A start sampled on the edge of the last decision launches the next conversion at once, so that results arrive every 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| cmp_i | input | 1 | Comparator decision, 1 = positive side higher |
| trim_i | input | 6 | Signed offset trim, subtracted from the code |
| sample_o | output | 1 | Input sampling switches closed |
| p_hi_o | output | 12 | Positive half, capacitor to reference-high |
| p_lo_o | output | 12 | Positive half, capacitor to reference-low |
| p_cm_o | output | 12 | Positive half, capacitor to common-mode |
| n_hi_o | output | 12 | Negative half, capacitor to reference-high |
| n_lo_o | output | 12 | Negative half, capacitor to reference-low |
| n_cm_o | output | 12 | Negative half, capacitor to common-mode |
| data_o | output | 12 | Trimmed conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |

## Verification
A behavioural comparator sums the weights of the capacitors that the switch buses have moved and compares the result with a held input and an injected offset. The result therefore depends on every switch direction being right, and a reversed or misplaced control shows up as a wrong code. Random inputs, offsets and trims across the whole range test the binary search and the trim arithmetic. Directed extreme inputs and trims separate the saturation at 0 from the saturation at 4095. Start and trim changes in mid-conversion, and a start on the last decision edge, separate the ignored requests from a correctly chained conversion.

// File: rtl/sar_vcm_ctrl.sv
module sar_vcm_ctrl #(
  parameter int NBITS      = 12,
  parameter int SAMPLE_CYC = 2,
  parameter int TRIM_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              sample_o,
  output logic [NBITS-1:0]  p_hi_o,
  output logic [NBITS-1:0]  p_lo_o,
  output logic [NBITS-1:0]  p_cm_o,
  output logic [NBITS-1:0]  n_hi_o,
  output logic [NBITS-1:0]  n_lo_o,
  output logic [NBITS-1:0]  n_cm_o,
  output logic [NBITS-1:0]  data_o,
  output logic              eoc_o
);

  localparam int CNT_MAX = (NBITS > SAMPLE_CYC) ? NBITS : SAMPLE_CYC;
  localparam int BW      = $clog2(CNT_MAX);
  localparam int DW      = NBITS + 2;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} state_t;

  state_t              st;
  logic [BW-1:0]       cnt;
  logic [NBITS-1:0]    bits;
  logic [NBITS-1:0]    moved;
  logic [TRIM_W-1:0]   trim_q;

  logic                last_dec;
  logic                accept;
  logic [NBITS-1:0]    raw_fin;
  logic signed [DW-1:0] diff;
  logic [NBITS-1:0]    sat_code;

  assign last_dec = (st == S_CONV) && (cnt == '0);
  assign accept   = start_i && ((st == S_IDLE) || last_dec);
  assign raw_fin  = {bits[NBITS-1:1], cmp_i};

  assign diff = $signed({2'b00, raw_fin})
              - $signed({{(DW-TRIM_W){trim_q[TRIM_W-1]}}, trim_q});

  always_comb begin
    if (diff[DW-1])
      sat_code = '0;
    else if (diff[DW-2])
      sat_code = '1;
    else
      sat_code = diff[NBITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bits   <= '0;
      moved  <= '0;
      trim_q <= '0;
      data_o <= '0;
      eoc_o  <= 1'b0;
    end else begin
      eoc_o <= 1'b0;
      if (last_dec) begin
        eoc_o  <= 1'b1;
        data_o <= sat_code;
      end
      if (accept) begin
        st     <= S_SAMP;
        cnt    <= '0;
        bits   <= '0;
        moved  <= '0;
        trim_q <= trim_i;
      end else begin
        unique case (st)
          S_SAMP: begin
            if (cnt == BW'(SAMPLE_CYC-1)) begin
              st  <= S_CONV;
              cnt <= BW'(NBITS-1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_CONV: begin
            if (cnt == '0) begin
              st    <= S_IDLE;
              bits  <= '0;
              moved <= '0;
            end else begin
              bits[cnt]  <= cmp_i;
              moved[cnt] <= 1'b1;
              cnt        <= cnt - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sample_o = (st == S_SAMP);

  for (genvar k = 0; k < NBITS; k++) begin : g_sw
    assign p_cm_o[k] = ~moved[k];
    assign p_lo_o[k] =  moved[k] &  bits[k];
    assign p_hi_o[k] =  moved[k] & ~bits[k];
    assign n_cm_o[k] = ~moved[k];
    assign n_hi_o[k] =  moved[k] &  bits[k];
    assign n_lo_o[k] =  moved[k] & ~bits[k];
  end

endmodule

// File: rtl/sar_vcm_ctrl_chk.sv
module sar_vcm_ctrl_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_o,
  input logic [NBITS-1:0] p_hi_o,
  input logic [NBITS-1:0] p_lo_o,
  input logic [NBITS-1:0] p_cm_o,
  input logic [NBITS-1:0] n_hi_o,
  input logic [NBITS-1:0] n_lo_o,
  input logic [NBITS-1:0] n_cm_o,
  input logic [NBITS-1:0] data_o,
  input logic             eoc_o
);

  for (genvar k = 0; k < NBITS; k++) begin : g_cap
    p_onehot_p_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({p_hi_o[k], p_lo_o[k], p_cm_o[k]}) == 1);
    p_onehot_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({n_hi_o[k], n_lo_o[k], n_cm_o[k]}) == 1);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_cm_o[k] && !$past(p_cm_o[k])) |-> $stable(p_lo_o[k]));
  end

  p_compl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_lo_o == n_hi_o) && (p_hi_o == n_lo_o) && (p_cm_o == n_cm_o));

  p_samp_cm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (&p_cm_o));

  p_msb_cm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_o) |-> (&p_cm_o));

  p_eoc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_o |-> $stable(data_o));

endmodule

bind sar_vcm_ctrl sar_vcm_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_o(sample_o),
  .p_hi_o(p_hi_o), .p_lo_o(p_lo_o), .p_cm_o(p_cm_o),
  .n_hi_o(n_hi_o), .n_lo_o(n_lo_o), .n_cm_o(n_cm_o),
  .data_o(data_o), .eoc_o(eoc_o)
);

// File: tb/sar_vcm_ctrl_tb.sv
`timescale 1ns/1ps
module sar_vcm_ctrl_tb;

  localparam int NB = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_i;
  logic [5:0]    trim_i = '0;
  logic          sample_o;
  logic [NB-1:0] p_hi_o, p_lo_o, p_cm_o, n_hi_o, n_lo_o, n_cm_o, data_o;
  logic          eoc_o;

  int ax = 0;
  int aoff = 0;
  int acc;
  int errors = 0;
  int checks = 0;
  int cycles_run = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sar_vcm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i), .trim_i(trim_i),
    .sample_o(sample_o), .p_hi_o(p_hi_o), .p_lo_o(p_lo_o), .p_cm_o(p_cm_o),
    .n_hi_o(n_hi_o), .n_lo_o(n_lo_o), .n_cm_o(n_cm_o),
    .data_o(data_o), .eoc_o(eoc_o)
  );

  // behavioural array + comparator: residue in half-LSB units
  always_comb begin
    acc = 2 * (ax + aoff) + 1;
    for (int k = 0; k < NB; k++) begin
      if (p_lo_o[k]) acc = acc - (1 << k);
      else if (p_hi_o[k]) acc = acc + (1 << k);
    end
    cmp_i = (acc > 0);
  end

  function automatic int clampc(int v);
    return (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
  endfunction

  function automatic int raw_code(int x, int off);
    return clampc(x + off + 2048);
  endfunction

  function automatic int exp_code(int x, int off, int trim);
    return clampc(raw_code(x, off) - trim);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // called at the negedge right after the start-accepting edge
  task automatic track(int x, int off, int trim, bit poke, bit chain, int trim2);
    int cyc = 0;
    int raw = raw_code(x, off);
    int expd = exp_code(x, off, trim);
    int prev = int'(data_o);
    bit b11 = raw[11];
    chk(sample_o && (&p_cm_o) && (&n_cm_o), "R4 sample cycle0", int'(sample_o), 1);
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1)
        chk(sample_o && (&p_cm_o), "R4 sample cycle1", int'(sample_o), 1);
      if (cyc == 2)
        chk(!sample_o && (&p_cm_o) && (&n_cm_o), "R4 msb cycle all cm", int'(p_cm_o), 4095);
      if (cyc == 3)
        chk(p_lo_o[11] == b11 && n_hi_o[11] == b11 && p_hi_o[11] == !b11 && !p_cm_o[11],
            "R5 msb cap direction", int'(p_lo_o[11]), int'(b11));
      if (cyc >= 3 && cyc < 14 && !eoc_o)
        chk(data_o == prev[NB-1:0], "R8 data held mid conversion", int'(data_o), prev);
      if (poke && cyc == 5) begin start_i = 1'b1; trim_i = 6'(trim + 7); end
      if (poke && cyc == 6) start_i = 1'b0;
      if (chain && cyc == 13) begin start_i = 1'b1; trim_i = 6'(trim2); end
      if (eoc_o || cyc > 40) break;
    end
    chk(cyc == 14, "R7 latency", cyc, 14);
    chk(int'(data_o) == expd, poke ? "R11 R9 result with mid-run start/trim" :
        (chain ? "R12 chained first result" : "R6 R9 R10 result"), int'(data_o), expd);
    if (chain) begin
      start_i = 1'b0;
      track(x, off, trim2, 1'b0, 1'b0, 0);
    end else begin
      prev = int'(data_o);
      @(negedge clk);
      chk(!eoc_o, "R7 eoc single cycle", int'(eoc_o), 0);
      chk(int'(data_o) == prev, "R8 data held after eoc", int'(data_o), prev);
      chk((&p_cm_o) && (&n_cm_o) && !sample_o, "R1 idle all cm", int'(p_cm_o), 4095);
    end
  endtask

  task automatic conv(int x, int off, int trim, bit poke, bit chain, int trim2);
    @(negedge clk);
    ax = x; aoff = off; trim_i = 6'(trim); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    track(x, off, trim, poke, chain, trim2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!eoc_o && data_o == 0 && !sample_o && (&p_cm_o) && (&n_cm_o),
        "R1 reset state", int'(data_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!eoc_o && (&p_cm_o) && (&n_cm_o) && !sample_o, "R1 idle after reset", int'(p_cm_o), 4095);

    conv(0, 0, 0, 0, 0, 0);
    conv(-1, 0, 0, 0, 0, 0);
    conv(2047, 0, 0, 0, 0, 0);
    conv(-2048, 0, 0, 0, 0, 0);
    conv(1234, 0, -32, 0, 0, 0);
    conv(0, 3, 31, 0, 0, 0);
    conv(2047, 5, -32, 0, 0, 0);   // R10 top saturation
    conv(-2048, -4, 31, 0, 0, 0);  // R10 bottom saturation
    conv(2040, 0, -20, 0, 0, 0);   // R10 top via trim only
    conv(-2040, 0, 20, 0, 0, 0);   // R10 bottom via trim only
    conv(500, -2, 9, 1, 0, 0);     // R11 / R9
    conv(-777, 1, -5, 0, 1, 17);   // R12 chained

    for (int i = 0; i < 60; i++) begin
      int x = int'($urandom_range(4095)) - 2048;
      int off = int'($urandom_range(10)) - 5;
      int tr = int'($urandom_range(63)) - 32;
      bit pk = ($urandom_range(3) == 0);
      bit ch = !pk && ($urandom_range(3) == 0);
      int t2 = int'($urandom_range(63)) - 32;
      conv(x, off, tr, pk, ch, t2);
    end
    summary();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles_run++;
      if (cycles_run > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles_run, 100000);
        summary();
      end
    end
  end

endmodule